// File: doc/BRIEF.md
# Error-Feedback DC Blocking Filter

This block strips the DC component from a stream of unsigned samples, taking one sample per clock and returning one signed result per clock. It forms the first difference of the input and adds a leaky copy of the previous output. The leak coefficient is one minus a power of two, so the feedback term is a shift and a subtract, and the whole recursion closes within one clock.

The accumulator keeps SHIFT fraction bits below the output LSB. Truncation to the output width floors the value. The bits that truncation drops are carried into the next sample, so the rounding loss is paid back over time and never builds up into an offset. The result saturates at the signed output range instead of wrapping. A strobe marks each valid input and each valid output, and the output strobe follows the input strobe by one clock.

Top module: `dc_block_ef`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_sample` is 0 until the first valid input is taken.
- R2: Reset clears the stored previous input, the previous output and the carried fraction. The first output after reset is therefore the first input value, saturated to the output range (65535 gives 32767).
- R3: For each valid input x (integer, LSB = 2^-15), the block first forms the integer accumulator acc = 2^S·(x − x_prev) + 2^S·y_prev − y_prev + f_prev, where S = SHIFT (default 6) and all values are integers in output LSB units. The output is y = floor(acc / 2^S), saturated, and the new carried fraction is f = acc mod 2^S, in the range 0 to 2^S − 1.
- R4: A constant input held long enough drives the output to exactly 0, whether the output decays from above or from below; it does not stick at −1 or +1.
- R5: The output saturates to the range −32768 to 32767 and never wraps. The saturated value is the y_prev used for the next sample, and the carried fraction is still the low S bits of acc.
- R6: A cycle with `in_valid` low changes no state: `out_sample` holds its value and the next valid input is processed as if the gap had not occurred.
- R7: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise.
- R8: Asserting `rst_n` in the middle of a stream clears the outputs at once, and processing restarts as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the chip's reset network |
| in_valid | input | 1 | High when `in_sample` carries a new sample |
| in_sample | input | IN_W (16) | Unsigned input, one integer bit |
| out_valid | output | 1 | High for one cycle for each accepted input, one clock later |
| out_sample | output | OUT_W (16) | Signed filtered output, same LSB weight as the input |

## Verification
A corrupted previous-input register shows on the very next output, as a spurious step of the wrong size. A wrong stored output or a wrong carried fraction also shows within one sample, because both feed straight into the next accumulation; the bench therefore compares every output against an independent model. A fraction that is lost or has the wrong sign hides for hundreds of samples and then appears as an output stuck at −1 or +1 under a constant input. The long hold tests cover both decay directions for this reason. Saturation faults show at once as a sign flip on a full-scale step.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  // Accumulator width: the wider of difference and output, the fraction
  // bits, and two guard bits for the difference-plus-feedback sum.
  function automatic int acc_width(input int diff_w, input int out_w,
                                   input int shift);
    return ((diff_w > out_w) ? diff_w : out_w) + shift + 2;
  endfunction

endpackage

// File: rtl/dcb_first_diff.sv
module dcb_first_diff #(
  parameter int IN_W = 16,
  localparam int DIFF_W = IN_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [IN_W-1:0]          sample,
  output logic signed [DIFF_W-1:0] diff
);

  logic [IN_W-1:0] prev_q;
  logic [IN_W-1:0] prev_d;

  always_comb begin
    prev_d = prev_q;
    if (en) prev_d = sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign diff = $signed({1'b0, sample}) - $signed({1'b0, prev_q});

endmodule

// File: rtl/dcb_quantizer.sv
module dcb_quantizer #(
  parameter int ACC_W = 25,
  parameter int OUT_W = 16,
  parameter int SHIFT = 6,
  localparam int Q_W = ACC_W - SHIFT
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic signed [OUT_W-1:0] y,
  output logic [SHIFT-1:0]        frac
);

  localparam logic signed [Q_W-1:0] QMAX =
    {{(Q_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [Q_W-1:0] QMIN =
    {{(Q_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [Q_W-1:0] q;

  // Dropping the low bits of a two's-complement value floors it.
  assign q    = acc[ACC_W-1:SHIFT];
  assign frac = acc[SHIFT-1:0];

  always_comb begin
    if (q > QMAX)      y = {1'b0, {(OUT_W-1){1'b1}}};
    else if (q < QMIN) y = {1'b1, {(OUT_W-1){1'b0}}};
    else               y = q[OUT_W-1:0];
  end

endmodule

// File: rtl/dcb_feedback.sv
module dcb_feedback #(
  parameter int DIFF_W = 17,
  parameter int OUT_W  = 16,
  parameter int SHIFT  = 6,
  parameter int ACC_W  = 25
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [DIFF_W-1:0] diff,
  output logic signed [OUT_W-1:0]  y_q
);

  logic [SHIFT-1:0]        e_q;
  logic [SHIFT-1:0]        e_d;
  logic signed [OUT_W-1:0] y_d;
  logic signed [ACC_W-1:0] diff_x;
  logic signed [ACC_W-1:0] y_x;
  logic signed [ACC_W-1:0] e_x;
  logic signed [ACC_W-1:0] acc;
  logic signed [OUT_W-1:0] y_new;
  logic [SHIFT-1:0]        e_new;

  assign diff_x = {{(ACC_W-DIFF_W){diff[DIFF_W-1]}}, diff};
  assign y_x    = {{(ACC_W-OUT_W){y_q[OUT_W-1]}}, y_q};
  assign e_x    = {{(ACC_W-SHIFT){1'b0}}, e_q};

  // p*y = y - y/2^S, exact in the extended scale; the carried fraction
  // is added back so the floor truncation leaves no lasting offset.
  assign acc = (diff_x <<< SHIFT) + (y_x <<< SHIFT) - y_x + e_x;

  dcb_quantizer #(
    .ACC_W (ACC_W),
    .OUT_W (OUT_W),
    .SHIFT (SHIFT)
  ) u_quant (
    .acc  (acc),
    .y    (y_new),
    .frac (e_new)
  );

  always_comb begin
    y_d = y_q;
    e_d = e_q;
    if (en) begin
      y_d = y_new;
      e_d = e_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
      e_q <= '0;
    end else begin
      y_q <= y_d;
      e_q <= e_d;
    end
  end

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(y_q) && $stable(e_q)); // R6

  AST_ZERO_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
    (en && diff == '0 && y_q == '0) |=> (y_q == '0)); // R4

endmodule

// File: rtl/dc_block_ef.sv
module dc_block_ef #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int SHIFT = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [IN_W-1:0]         in_sample,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);

  localparam int DIFF_W = IN_W + 1;
  localparam int ACC_W  = dcb_pkg::acc_width(DIFF_W, OUT_W, SHIFT);

  logic signed [DIFF_W-1:0] diff;
  logic                     valid_d;

  dcb_first_diff #(
    .IN_W (IN_W)
  ) u_diff (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_valid),
    .sample (in_sample),
    .diff   (diff)
  );

  dcb_feedback #(
    .DIFF_W (DIFF_W),
    .OUT_W  (OUT_W),
    .SHIFT  (SHIFT),
    .ACC_W  (ACC_W)
  ) u_loop (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_valid),
    .diff  (diff),
    .y_q   (out_sample)
  );

  assign valid_d = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample)); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !diff[DIFF_W-1] && !out_sample[OUT_W-1])
      |=> !out_sample[OUT_W-1]); // R5

endmodule

// File: tb/dc_block_ef_test.sv
module dc_block_ef_test;

  localparam int S = 6;

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic [15:0]        in_sample;
  logic               out_valid;
  logic signed [15:0] out_sample;

  int errors = 0;
  int checks = 0;
  longint xp, yp, fp;

  dc_block_ef uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model_step(input longint x);
    longint d, acc, q, y;
    d   = x - xp;
    acc = (d <<< S) + (yp <<< S) - yp + fp;
    q   = acc >>> S;
    fp  = acc - (q <<< S);
    y   = (q > 32767) ? 32767 : ((q < -32768) ? -32768 : q);
    xp  = x;
    yp  = y;
    return y;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sample = '0;
    xp = 0; yp = 0; fp = 0;
    @(negedge clk);
    check("R8 valid in reset", longint'(out_valid), 0);
    check("R8 sample in reset", longint'(out_sample), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Called at a negedge; returns at the next negedge after checking.
  task automatic send(input logic [15:0] x, input string req, output longint y);
    in_valid = 1'b1;
    in_sample = x;
    y = model_step(longint'(x));
    @(negedge clk);
    check("R7 out_valid after input", longint'(out_valid), 1);
    check(req, longint'(out_sample), y);
  endtask

  task automatic go_idle(input int n);
    longint held;
    in_valid = 1'b0;
    held = longint'(out_sample);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R7 out_valid idle", longint'(out_valid), 0);
      check("R6 sample held", longint'(out_sample), held);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 out_sample after reset", longint'(out_sample), 0);
    @(negedge clk);
    check("R1 out_valid still low", longint'(out_valid), 0);
  endtask

  task automatic t_first_sample();
    longint y;
    send(16'd12000, "R2 first output", y);
    check("R2 first equals input", longint'(out_sample), 12000);
    go_idle(1);
  endtask

  task automatic t_dc_hold();
    longint y;
    for (int i = 0; i < 1500; i++) send(16'd20000, "R3 decay from above", y);
    check("R4 settles to zero from above", longint'(out_sample), 0);
    for (int i = 0; i < 1500; i++) send(16'd5000, "R3 decay from below", y);
    check("R4 settles to zero from below", longint'(out_sample), 0);
    go_idle(1);
  endtask

  task automatic t_saturation();
    longint y;
    do_reset();
    send(16'hFFFF, "R5 full-scale step", y);
    check("R5 clip high", longint'(out_sample), 32767);
    send(16'h0000, "R5 full-scale drop", y);
    check("R5 clip low", longint'(out_sample), -32768);
    for (int i = 0; i < 20; i++) send(16'h0000, "R5 recovery after clip", y);
    go_idle(1);
  endtask

  task automatic t_gaps();
    longint y;
    send(16'd30000, "R6 before gap", y);
    go_idle(5);
    send(16'd30000, "R6 after gap", y);
    send(16'd100, "R6 step after gap", y);
    go_idle(2);
  endtask

  task automatic t_pattern();
    logic [15:0] lf;
    longint y;
    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      send(lf, "R3 pseudo-random stream", y);
    end
    go_idle(1);
  endtask

  task automatic t_mid_reset();
    longint y;
    send(16'd40000, "R8 before reset", y);
    send(16'd1000, "R8 before reset", y);
    do_reset();
    send(16'd777, "R8 restart", y);
    check("R8 restart equals input", longint'(out_sample), 777);
    go_idle(1);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sample = '0;
    t_reset_state();
    t_first_sample();
    t_dc_hold();
    t_saturation();
    t_gaps();
    t_pattern();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule